// File: doc/BRIEF.md
# Walking-One Interconnect Test Packet Source

This block sits at one node of a 2x2 mesh network and produces the stimulus side of an interconnect test. When it sees a start pulse it sends one packet of flits into the local router over a valid/ready link, each flit carrying a tag that marks it as header, body or tail. The packet opens with a routing header, then sends a run of all-zero flits long enough to clear every link on the path. After that comes the walking-one payload and, last, a tail flit.

The payload is divided into slots, one per vector position of the whole network (nodes times channel width). Each slot is one vector flit followed by a fixed number of zero flits that lets the vector drain out of the path. A node only puts a set bit into the slots that belong to its own index, and leaves every other slot at zero. All four nodes start together, so at any moment at most one wire of the mesh carries a '1', and every pair of wires can be told apart. Node index, header value and header mask are set by parameters.

Top module: `wo_pkt_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `flit_valid_o` is 0, `flit_data_o` is all zero and `flit_tag_o` is 2'b00.
- R2: With no packet in progress, the block stays idle until `start_i` is sampled high. The first flit after that is the header: tag 2'b01, data equal to `HDR_VALUE & HDR_MASK`, so that bits outside the mask are zero.
- R3: The header is followed by exactly `H_ZEROS` flits (9 by default) with tag 2'b00 and all-zero data.
- R4: The payload is `NUM_NODES*FLIT_W` slots of `1+L_ZEROS` flits, all with tag 2'b00. The first flit of slot k carries only bit (k - FLIT_W*NODE_IDX) set when FLIT_W*NODE_IDX <= k < FLIT_W*(NODE_IDX+1), and is zero otherwise. The other flits of every slot are zero, so the set bit walks up from bit 0 one position per vector.
- R5: The packet ends with one tail flit (tag 2'b10, zero data), after which `flit_valid_o` drops. With default parameters a packet is exactly 171 flits long.
- R6: A flit is taken only in a cycle with `flit_valid_o` and `flit_ready_i` both high. While valid is high and ready is low, data and tag hold their values in the next cycle.
- R7: A start pulse while a packet is in progress, including the cycle in which the tail is taken, has no effect: the packet continues unchanged and no second packet follows it.
- R8: Within a packet, at most one data bit is set in any flit tagged 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Pulse that begins a packet when idle |
| flit_ready_i | input | 1 | Router can take the presented flit |
| flit_valid_o | output | 1 | A flit is presented |
| flit_data_o | output | FLIT_W | Flit contents |
| flit_tag_o | output | 2 | Framing: 00 body, 01 header, 10 tail |

## Verification
Two events can fall in the same cycle: the router taking the tail flit, and a new start pulse. The bench raises start exactly on the cycle where the tail is presented with ready high, and then requires that valid is low on the following cycle, with no new header. It also pulses start in the middle of a packet that is stalled at random by ready. Each flit taken must still match the expected sequence computed in the bench, and the packet length must still come out to 171.

// File: rtl/wo_pkt_pkg.sv
package wo_pkt_pkg;

    typedef enum logic [1:0] {
        TAG_BODY = 2'b00,
        TAG_HEAD = 2'b01,
        TAG_TAIL = 2'b10
    } flit_tag_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HEAD,
        PH_FLUSH,
        PH_PAY,
        PH_TAIL
    } phase_e;

    // Whole packet length in flits for a given set of parameters.
    function automatic int unsigned packet_flits(int unsigned h, int unsigned l,
                                                 int unsigned w, int unsigned n);
        return 1 + h + n * w * (1 + l) + 1;
    endfunction

    // Counter width able to hold 0..max_val (at least one bit).
    function automatic int unsigned cnt_width(int unsigned max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/wo_pkt_seq.sv
module wo_pkt_seq
    import wo_pkt_pkg::*;
#(
    parameter int unsigned H_ZEROS = 9,
    parameter int unsigned L_ZEROS = 4,
    parameter int unsigned N_SLOTS = 32,
    localparam int unsigned SLOT_W = cnt_width(N_SLOTS - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              adv_i,
    output phase_e            phase_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              lead_o
);

    localparam int unsigned CNT_MAX = (H_ZEROS > L_ZEROS) ? H_ZEROS : L_ZEROS;
    localparam int unsigned CNT_W   = cnt_width(CNT_MAX);
    localparam logic [CNT_W-1:0] FLUSH_LAST = CNT_W'((H_ZEROS == 0) ? 0 : H_ZEROS - 1);
    localparam logic [CNT_W-1:0] SUB_LAST   = CNT_W'(L_ZEROS);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_SLOTS - 1);
    localparam phase_e AFTER_HEAD = (H_ZEROS > 0) ? PH_FLUSH : PH_PAY;

    phase_e             phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [SLOT_W-1:0]  slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            slot_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_HEAD;
                    end
                end
                PH_HEAD: begin
                    if (adv_i) begin
                        phase_q <= AFTER_HEAD;
                        cnt_q   <= '0;
                        slot_q  <= '0;
                    end
                end
                PH_FLUSH: begin
                    if (adv_i) begin
                        if (cnt_q == FLUSH_LAST) begin
                            phase_q <= PH_PAY;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_PAY: begin
                    if (adv_i) begin
                        if (cnt_q == SUB_LAST) begin
                            cnt_q <= '0;
                            if (slot_q == SLOT_LAST) begin
                                phase_q <= PH_TAIL;
                            end else begin
                                slot_q <= slot_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_TAIL: begin
                    if (adv_i) begin
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign slot_o  = slot_q;
    assign lead_o  = (cnt_q == '0);

endmodule

// File: rtl/wo_pkt_flit.sv
module wo_pkt_flit
    import wo_pkt_pkg::*;
#(
    parameter int unsigned FLIT_W   = 8,
    parameter int unsigned NODE_IDX = 0,
    parameter int unsigned SLOT_W   = 5,
    parameter logic [FLIT_W-1:0] HDR_VALUE = '0,
    parameter logic [FLIT_W-1:0] HDR_MASK  = '1
) (
    input  phase_e            phase_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              lead_i,
    output logic              valid_o,
    output logic [FLIT_W-1:0] data_o,
    output flit_tag_e         tag_o
);

    localparam int unsigned BASE = NODE_IDX * FLIT_W;
    localparam logic [FLIT_W-1:0] HDR_FLIT = HDR_VALUE & HDR_MASK;

    logic [FLIT_W-1:0] walk;

    // One comparator per channel bit: bit b is set only in the node's own
    // slot number BASE+b, and only on the vector flit of that slot.
    for (genvar b = 0; b < FLIT_W; b++) begin : g_walk
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(BASE + b);
        assign walk[b] = (phase_i == PH_PAY) && lead_i && (slot_i == MY_SLOT);
    end

    always_comb begin
        data_o = '0;
        tag_o  = TAG_BODY;
        unique case (phase_i)
            PH_HEAD: begin
                data_o = HDR_FLIT;
                tag_o  = TAG_HEAD;
            end
            PH_PAY:  data_o = walk;
            PH_TAIL: tag_o  = TAG_TAIL;
            default: ;
        endcase
    end

    assign valid_o = (phase_i != PH_IDLE);

endmodule

// File: rtl/wo_pkt_gen.sv
module wo_pkt_gen
    import wo_pkt_pkg::*;
#(
    parameter int unsigned FLIT_W    = 8,
    parameter int unsigned NUM_NODES = 4,
    parameter int unsigned NODE_IDX  = 0,
    parameter int unsigned H_ZEROS   = 9,
    parameter int unsigned L_ZEROS   = 4,
    parameter logic [FLIT_W-1:0] HDR_VALUE = 8'h11,
    parameter logic [FLIT_W-1:0] HDR_MASK  = 8'h99
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              flit_ready_i,
    output logic              flit_valid_o,
    output logic [FLIT_W-1:0] flit_data_o,
    output logic [1:0]        flit_tag_o
);

    localparam int unsigned N_SLOTS = NUM_NODES * FLIT_W;
    localparam int unsigned SLOT_W  = cnt_width(N_SLOTS - 1);

    phase_e             phase;
    logic [SLOT_W-1:0]  slot;
    logic               lead;
    logic               valid;
    flit_tag_e          tag;
    logic [FLIT_W-1:0]  data;

    wo_pkt_seq #(
        .H_ZEROS (H_ZEROS),
        .L_ZEROS (L_ZEROS),
        .N_SLOTS (N_SLOTS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .adv_i   (valid & flit_ready_i),
        .phase_o (phase),
        .slot_o  (slot),
        .lead_o  (lead)
    );

    wo_pkt_flit #(
        .FLIT_W    (FLIT_W),
        .NODE_IDX  (NODE_IDX),
        .SLOT_W    (SLOT_W),
        .HDR_VALUE (HDR_VALUE),
        .HDR_MASK  (HDR_MASK)
    ) u_flit (
        .phase_i (phase),
        .slot_i  (slot),
        .lead_i  (lead),
        .valid_o (valid),
        .data_o  (data),
        .tag_o   (tag)
    );

    assign flit_valid_o = valid;
    assign flit_data_o  = data;
    assign flit_tag_o   = tag;

endmodule

// File: rtl/wo_pkt_chk.sv
module wo_pkt_chk #(
    parameter int unsigned FLIT_W  = 8,
    parameter int unsigned PKT_LEN = 171
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              flit_ready_i,
    input logic              flit_valid_o,
    input logic [FLIT_W-1:0] flit_data_o,
    input logic [1:0]        flit_tag_o
);

    logic        fire;
    logic [15:0] taken_q;

    assign fire = flit_valid_o && flit_ready_i;

    // Flits taken so far in the current packet.
    always_ff @(posedge clk) begin
        if (rst || !flit_valid_o) begin
            taken_q <= '0;
        end else if (fire) begin
            taken_q <= taken_q + 16'd1;
        end
    end

    a_r2_start_gives_header: assert property (@(posedge clk) disable iff (rst)
        (!flit_valid_o && start_i) |=> (flit_valid_o && flit_tag_o == 2'b01));

    a_r3_single_header: assert property (@(posedge clk) disable iff (rst)
        (fire && flit_tag_o == 2'b01) |=> (flit_valid_o && flit_tag_o != 2'b01));

    a_r5_idle_after_tail: assert property (@(posedge clk) disable iff (rst)
        (fire && flit_tag_o == 2'b10) |=> !flit_valid_o);

    a_r5_packet_length: assert property (@(posedge clk) disable iff (rst)
        (fire && flit_tag_o == 2'b10) |-> (taken_q == 16'(PKT_LEN - 1)));

    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (flit_valid_o && !flit_ready_i) |=>
            (flit_valid_o && $stable(flit_data_o) && $stable(flit_tag_o)));

    a_r7_busy_start_no_abort: assert property (@(posedge clk) disable iff (rst)
        (flit_valid_o && start_i && !(fire && flit_tag_o == 2'b10)) |=> flit_valid_o);

    a_r8_body_onehot0: assert property (@(posedge clk) disable iff (rst)
        (flit_valid_o && flit_tag_o == 2'b00) |-> $onehot0(flit_data_o));

endmodule

bind wo_pkt_gen wo_pkt_chk #(
    .FLIT_W  (FLIT_W),
    .PKT_LEN (wo_pkt_pkg::packet_flits(H_ZEROS, L_ZEROS, FLIT_W, NUM_NODES))
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .flit_ready_i (flit_ready_i),
    .flit_valid_o (flit_valid_o),
    .flit_data_o  (flit_data_o),
    .flit_tag_o   (flit_tag_o)
);

// File: tb/sim_wo_pkt_gen.sv
`timescale 1ns/1ps
module sim_wo_pkt_gen;

    localparam int W    = 8;
    localparam int NN   = 4;
    localparam int NODE = 2;
    localparam int HZ   = 9;
    localparam int LZ   = 4;
    localparam logic [7:0] HV = 8'hB6;
    localparam logic [7:0] HM = 8'h99;
    localparam int PLEN = 1 + HZ + NN * W * (1 + LZ) + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       ready = 1'b0;
    logic       valid;
    logic [7:0] data;
    logic [1:0] tag;

    int checks = 0;
    int failures = 0;
    int unsigned seed_init;

    always #10 clk = ~clk;

    wo_pkt_gen #(
        .FLIT_W (W), .NUM_NODES (NN), .NODE_IDX (NODE),
        .H_ZEROS (HZ), .L_ZEROS (LZ), .HDR_VALUE (HV), .HDR_MASK (HM)
    ) u0 (
        .clk (clk), .rst (rst), .start_i (start), .flit_ready_i (ready),
        .flit_valid_o (valid), .flit_data_o (data), .flit_tag_o (tag)
    );

    // Expected {tag, data} of flit j of a packet, from the requirements.
    function automatic logic [9:0] exp_flit(int j);
        int p, slot, sub;
        if (j == 0) return {2'b01, HV & HM};
        if (j == PLEN - 1) return {2'b10, 8'h00};
        if (j <= HZ) return {2'b00, 8'h00};
        p = j - 1 - HZ;
        slot = p / (1 + LZ);
        sub = p % (1 + LZ);
        if (sub == 0 && slot / W == NODE) return {2'b00, 8'(1 << (slot % W))};
        return {2'b00, 8'h00};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // mode 0: ready always high; 1: random ready, mid-packet start at cycle
    // start_at; 2: random ready, start on the tail-accept cycle.
    task automatic run_packet(input int mode, input int start_at);
        int k = 0;
        int cyc = 0;
        bit done = 0;
        bit pv = 0, pr = 0;
        logic [7:0] pd = '0;
        logic [1:0] pt = '0;
        logic [9:0] e;
        @(negedge clk) start = 1'b1;
        while (!done) begin
            @(negedge clk);
            ready = (mode == 0) ? 1'b1 : (($urandom % 4) != 0);
            start = (mode == 1 && cyc == start_at) ||
                    (mode == 2 && valid && ready && tag == 2'b10);
            // R6: stalled flit held
            if (pv && !pr)
                check(valid && data == pd && tag == pt, "R6 stall hold",
                      {21'd0, valid, tag, data}, {21'd0, 1'b1, pt, pd});
            if (cyc == 0)
                check(valid && tag == 2'b01, "R2 header after start",
                      {30'd0, tag}, 32'd1);
            if (valid && ready) begin
                e = exp_flit(k);
                if (k == 0)
                    check({tag, data} == e, "R2 header value", {tag, data}, e);
                else if (k <= HZ)
                    check({tag, data} == e, "R3 flush zero", {tag, data}, e);
                else if (k < PLEN - 1)
                    check({tag, data} == e, "R4 payload", {tag, data}, e);
                else
                    check({tag, data} == e, "R5 tail", {tag, data}, e);
                if (tag == 2'b10) done = 1;
                k++;
            end
            pv = valid; pr = ready; pd = data; pt = tag;
            cyc++;
        end
        @(negedge clk);
        start = 1'b0;
        check(k == PLEN, "R5 packet length", k, PLEN);
        check(!valid, (mode == 2) ? "R7 start at tail ignored" : "R5 idle after tail",
              {31'd0, valid}, 32'd0);
        repeat (3) @(negedge clk);
        check(!valid, "R7 no second packet", {31'd0, valid}, 32'd0);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 20000) begin
                failures++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        seed_init = $urandom(32'h5EED);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        check(!valid && data == 8'h00 && tag == 2'b00, "R1 reset state",
              {22'd0, valid, tag, data}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!valid && data == 8'h00 && tag == 2'b00, "R1 after reset",
              {22'd0, valid, tag, data}, 32'd0);
        // R2: no start, stays idle even with ready high
        ready = 1'b1;
        repeat (5) @(negedge clk);
        check(!valid, "R2 idle without start", {31'd0, valid}, 32'd0);

        run_packet(0, 0);
        run_packet(1, 40);
        run_packet(1, 3);
        run_packet(2, 0);
        run_packet(2, 0);

        finish_run();
    end

endmodule